// File: doc/BRIEF.md
# Bridge Configuration Status Register

This block holds the 16-bit status word that a bridge function exposes in its configuration space. Logic on the link side reports error events as one-cycle pulses. Each pulse sets its own sticky bit, and that bit stays at one until software clears it. Two of the set conditions also depend on enable bits from the companion command register. This block receives those enables as plain inputs.

Software reads the word through a combinational read port. It clears bits through a write port with two byte enables, where writing a one to a bit clears it. The capability bit and all reserved or hardwired bits always return fixed values.

Top module: `bridge_status_reg`

## Requirements
- R1: While reset is asserted, and after it is released, the read value is 16'h0010.
- R2: A pulse on `ev_poison_rx` sets bit 15, whatever the value of `en_parity_resp`.
- R3: A pulse on `ev_err_msg_tx` sets bit 14 only when `en_sys_err` is 1. When `en_sys_err` is 0, bit 14 is left unchanged.
- R4: A pulse on `ev_cpl_ur_rx` sets bit 13.
- R5: A pulse on `ev_cpl_ca_rx` sets bit 12.
- R6: A pulse on `ev_cpl_ca_tx` sets bit 11.
- R7: Bit 8 is set when `en_parity_resp` is 1 and either `ev_poison_cpl_rx` or `ev_poison_wr_rx` pulses. When `en_parity_resp` is 0, neither event changes bit 8.
- R8: Bit 4 always reads 1. Bits 10:9, 7:5 and 3:0 always read 0. Writes to these bits have no effect.
- R9: A write with `wr_be[1]` = 1 clears each of bits 15:11 and 8 whose `wr_data` bit is 1. Bits written with 0 keep their value. `wr_be[0]` covers bits 7:0, so it clears no sticky bit. A write with `wr_be[1]` = 0 clears nothing.
- R10: If a bit's set event and a clear of that bit fall in the same cycle, the bit ends at 1.
- R11: A sticky bit with neither a set nor a clear in a cycle keeps its value.
- R12: `rd_data` shows the register value as it stood before any write in the same cycle. A write takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_parity_resp | input | 1 | Parity-error-response enable from the command register |
| en_sys_err | input | 1 | System-error enable from the command register |
| ev_poison_rx | input | 1 | Poisoned packet received (pulse) |
| ev_err_msg_tx | input | 1 | Fatal or non-fatal error message sent (pulse) |
| ev_cpl_ur_rx | input | 1 | Completion with Unsupported Request status received (pulse) |
| ev_cpl_ca_rx | input | 1 | Completion with Completer Abort status received (pulse) |
| ev_cpl_ca_tx | input | 1 | Request completed by this bridge with Completer Abort status (pulse) |
| ev_poison_cpl_rx | input | 1 | Poisoned completion with data received (pulse) |
| ev_poison_wr_rx | input | 1 | Received write request is poisoned (pulse) |
| wr_en | input | 1 | Configuration write strobe |
| wr_be | input | 2 | Byte enables: bit 0 covers bits 7:0, bit 1 covers bits 15:8 |
| wr_data | input | 16 | Write data; a one clears the matching sticky bit |
| rd_data | output | 16 | Current status value |

## Verification
The hardest case to reach from the ports is a set event and a clear of the same bit landing on the same edge, together with the enable gating of bits 14 and 8. Random stimulus alone only hits these combinations now and then. The bench therefore drives directed cycles that raise an event together with a matching one-to-clear write. It also drives cycles that pulse the gated events with their enables held low. Biased random traffic then mixes events, enables and partial byte-enable writes. A reset asserted mid-run shows that the sticky bits return to their reset value.

// File: rtl/bridge_status_reg.sv
module bridge_status_reg #(
  parameter logic [15:0] RESET_VAL   = 16'h0010,
  parameter logic [15:0] STICKY_MASK = 16'hF900
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_parity_resp,
  input  logic        en_sys_err,
  input  logic        ev_poison_rx,
  input  logic        ev_err_msg_tx,
  input  logic        ev_cpl_ur_rx,
  input  logic        ev_cpl_ca_rx,
  input  logic        ev_cpl_ca_tx,
  input  logic        ev_poison_cpl_rx,
  input  logic        ev_poison_wr_rx,
  input  logic        wr_en,
  input  logic [1:0]  wr_be,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data
);
  localparam logic [15:0] FIXED_VAL = RESET_VAL & ~STICKY_MASK;

  logic [15:0] sticky_q;
  logic [15:0] set_vec;
  logic [15:0] clr_vec;
  logic [15:0] be_mask;

  assign set_vec = {ev_poison_rx,
                    ev_err_msg_tx & en_sys_err,
                    ev_cpl_ur_rx,
                    ev_cpl_ca_rx,
                    ev_cpl_ca_tx,
                    2'b00,
                    en_parity_resp & (ev_poison_cpl_rx | ev_poison_wr_rx),
                    8'h00} & STICKY_MASK;

  assign be_mask = {{8{wr_be[1]}}, {8{wr_be[0]}}};
  assign clr_vec = {16{wr_en}} & be_mask & wr_data & STICKY_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= RESET_VAL & STICKY_MASK;
    else        sticky_q <= set_vec | (sticky_q & ~clr_vec);
  end

  assign rd_data = (sticky_q & STICKY_MASK) | FIXED_VAL;

  // R2: poisoned packet sets bit 15, regardless of the parity enable
  p_poison_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_poison_rx |=> rd_data[15]);

  // R3: error message with the system-error enable low leaves bit 14 alone
  p_serr_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err_msg_tx && !en_sys_err && !(wr_en && wr_be[1] && wr_data[14]))
      |=> rd_data[14] == $past(rd_data[14]));

  // R7: poisoned data events with the parity enable low leave bit 8 alone
  p_dpar_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_parity_resp && !(wr_en && wr_be[1] && wr_data[8]))
      |=> rd_data[8] == $past(rd_data[8]));

  // R9: a one-to-clear write with no set event drops bit 13
  p_clear_works_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && wr_data[13] && !ev_cpl_ur_rx) |=> !rd_data[13]);

  // R10: a set event wins over a clear in the same cycle
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cpl_ca_tx && wr_en && wr_be[1] && wr_data[11]) |=> rd_data[11]);

  // R11: with no set and no clear, bit 12 holds its value
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_cpl_ca_rx && !(wr_en && wr_be[1] && wr_data[12]))
      |=> $stable(rd_data[12]));
endmodule

// File: tb/tb_bridge_status_reg.sv
module tb_bridge_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_parity_resp = 1'b0, en_sys_err = 1'b0;
  logic ev_poison_rx = 1'b0, ev_err_msg_tx = 1'b0, ev_cpl_ur_rx = 1'b0;
  logic ev_cpl_ca_rx = 1'b0, ev_cpl_ca_tx = 1'b0;
  logic ev_poison_cpl_rx = 1'b0, ev_poison_wr_rx = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] exp_q;

  always #10 clk = ~clk;

  bridge_status_reg dut (
    .clk(clk), .rst_n(rst_n),
    .en_parity_resp(en_parity_resp), .en_sys_err(en_sys_err),
    .ev_poison_rx(ev_poison_rx), .ev_err_msg_tx(ev_err_msg_tx),
    .ev_cpl_ur_rx(ev_cpl_ur_rx), .ev_cpl_ca_rx(ev_cpl_ca_rx),
    .ev_cpl_ca_tx(ev_cpl_ca_tx), .ev_poison_cpl_rx(ev_poison_cpl_rx),
    .ev_poison_wr_rx(ev_poison_wr_rx), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [15:0] model_next(input logic [15:0] cur);
    logic [15:0] s;
    logic [15:0] c;
    s = 16'h0000;
    s[15] = ev_poison_rx;
    s[14] = ev_err_msg_tx && en_sys_err;
    s[13] = ev_cpl_ur_rx;
    s[12] = ev_cpl_ca_rx;
    s[11] = ev_cpl_ca_tx;
    s[8]  = en_parity_resp && (ev_poison_cpl_rx || ev_poison_wr_rx);
    c = 16'h0000;
    if (wr_en && wr_be[1]) c = wr_data & 16'hF900;
    return s | (cur & ~c) | 16'h0010;
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, rd_data, exp);
    end
  endtask

  task automatic idle_inputs();
    {ev_poison_rx, ev_err_msg_tx, ev_cpl_ur_rx, ev_cpl_ca_rx, ev_cpl_ca_tx,
     ev_poison_cpl_rx, ev_poison_wr_rx, wr_en} = '0;
    wr_be = 2'b00;
    wr_data = 16'h0000;
  endtask

  // inputs applied after a falling edge; rd_data checked unchanged (R12), then after edge
  task automatic step(input string tag);
    check("R12 pre-edge read", exp_q);
    exp_q = model_next(exp_q);
    @(negedge clk);
    check(tag, exp_q);
    idle_inputs();
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    wr_en = 1'b1; wr_be = be; wr_data = d;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=%h exp=%h", rd_data, exp_q);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    exp_q = 16'h0010;
    #5;
    check("R1 in reset", 16'h0010);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 16'h0010);

    // R2 with parity enable low
    en_parity_resp = 1'b0; ev_poison_rx = 1'b1; step("R2 poison sets 15");
    // R7 gated off
    ev_poison_cpl_rx = 1'b1; ev_poison_wr_rx = 1'b1; step("R7 gated off");
    // R3 gated off, then on
    en_sys_err = 1'b0; ev_err_msg_tx = 1'b1; step("R3 gated off");
    en_sys_err = 1'b1; ev_err_msg_tx = 1'b1; step("R3 enabled");
    ev_cpl_ur_rx = 1'b1; step("R4 UR sets 13");
    ev_cpl_ca_rx = 1'b1; step("R5 CA rx sets 12");
    ev_cpl_ca_tx = 1'b1; step("R6 CA tx sets 11");
    en_parity_resp = 1'b1; ev_poison_wr_rx = 1'b1; step("R7 poisoned write");
    wr(2'b01, 16'hFFFF); step("R9 low byte enable clears nothing");
    wr(2'b10, 16'h0000); step("R9 zero write keeps bits");
    wr(2'b11, 16'h06F7); step("R8 fixed bits ignore writes");
    wr(2'b10, 16'h8100); step("R9 clear 15 and 8");
    en_parity_resp = 1'b1; ev_poison_cpl_rx = 1'b1; step("R7 poisoned completion");
    ev_cpl_ca_tx = 1'b1; wr(2'b11, 16'hFFFF); step("R10 set beats clear");
    wr(2'b00, 16'hFFFF); step("R9 no byte enable");
    step("R11 idle hold");
    wr(2'b10, 16'hFFFF); step("R9 clear all");

    for (int i = 0; i < 400; i++) begin
      en_parity_resp   = $urandom_range(0, 1);
      en_sys_err       = $urandom_range(0, 1);
      ev_poison_rx     = ($urandom_range(0, 7) == 0);
      ev_err_msg_tx    = ($urandom_range(0, 5) == 0);
      ev_cpl_ur_rx     = ($urandom_range(0, 7) == 0);
      ev_cpl_ca_rx     = ($urandom_range(0, 7) == 0);
      ev_cpl_ca_tx     = ($urandom_range(0, 7) == 0);
      ev_poison_cpl_rx = ($urandom_range(0, 6) == 0);
      ev_poison_wr_rx  = ($urandom_range(0, 6) == 0);
      if ($urandom_range(0, 3) == 0) wr(2'($urandom_range(0, 3)), 16'($urandom));
      step("R2-R11 random mix");
    end

    ev_cpl_ur_rx = 1'b1; step("R4 before reset");
    rst_n = 1'b0;
    #1;
    exp_q = 16'h0010;
    check("R1 mid-run reset", 16'h0010);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 released", 16'h0010);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule